// File: doc/BRIEF.md
# Four-Channel Line Fault Status and Interrupt Unit

This unit watches four line-driver channels and turns their raw fault flags into clean status. Each channel's raw over-current flag is filtered so that the channel is marked overloaded only after the flag has stayed high without a break for a set number of time-base ticks. With a 1 ms tick and the default of 20 ticks, that window is 20 ms. The filtered overload bits feed one active-low interrupt. A channel counts toward that interrupt only while its line is enabled and it has not been shut down for thermal overload.

One set of four pads has two uses. In parallel mode each pad is an open-drain status line. It lets go (high impedance) when the channel is overloaded, when the chip's thermal alarm is raised, or when the channel's driver is powering up. A low channel-enable input forces that pad to pull low. In bus mode the same pads form a 4-bit bidirectional data bus gated by chip select, read strobe and write strobe. A read returns the four filtered overload bits. The pads are modelled as a data vector and an output-enable vector, which a pad ring turns into the real tri-state cells.

Top module: `quad_line_monitor`

## Requirements
- R1: A channel's overload bit becomes 1 only after exactly PERSIST_TICKS ticks have been sampled while its synchronised raw flag was high without a break. After PERSIST_TICKS-1 such ticks it is still 0.
- R2: When a synchronised raw flag goes low, that channel's count and overload bit clear on the next clock edge. A burst shorter than the window, followed by a new burst that is also short, never sets the bit.
- R3: `irq_n_o` is a registered output. It goes low one clock after a qualified overload bit is 1, and it returns high one clock after no overload bit is qualified. A bit is qualified when it is set, its line is enabled and the channel is not thermally shut down.
- R4: A high `therm_shut_i[n]` or a low `line_en_i[n]` removes channel n from the interrupt. The interrupt releases one clock later if no other channel is qualified.
- R5: `irq_n_o` is high after any clock edge at which `irq_en_i` is 0 or `rst_n` is 0.
- R6: In parallel mode (`bus_mode_i`=0) with the channel enabled, `pad_oe_o[n]` is 0 (released) when the overload bit, the thermal alarm or `pwr_up_i[n]` is active. Otherwise it is 1, and `pad_do_o[n]` is 0.
- R7: In parallel mode, `ch_en_i[n]`=0 forces `pad_oe_o[n]`=1 and `pad_do_o[n]`=0, whatever the fault state.
- R8: In bus mode (`bus_mode_i`=1), `pad_oe_o` is 0 while `cs_n_i`=1, and also while `cs_n_i`=0 with `wr_n_i`=0. A pending write takes priority over a read.
- R9: In bus mode, with `cs_n_i`=0, `rd_n_i`=0 and `wr_n_i`=1, `pad_oe_o` is all ones and `pad_do_o[n]` is channel n's overload bit. Channel 0 is on bit 0, and a 1 means overloaded.
- R10: A clock edge with `rst_n`=0 clears every persistence count, every overload bit and the synchronisers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| ovc_raw_i | input | 4 | Raw over-current flags, asynchronous |
| therm_alarm_i | input | 1 | Chip thermal alarm, asynchronous |
| pwr_up_i | input | 4 | Per-channel driver power-on phase, asynchronous |
| ch_en_i | input | 4 | Channel enable; 0 pulls the status pad low in parallel mode |
| line_en_i | input | 4 | Line enable for the interrupt qualification |
| therm_shut_i | input | 4 | Per-channel automatic thermal shutdown |
| irq_en_i | input | 1 | Interrupt enable |
| bus_mode_i | input | 1 | 0 parallel status, 1 data bus |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| pad_do_o | output | 4 | Pad output data |
| pad_oe_o | output | 4 | Pad output enable, 1 = drive |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
A raw flag takes two clocks through its synchroniser, so the bench waits three clocks after changing one before it starts ticking, and four clocks after dropping one before it looks for the clear. Each tick is counted at the edge where it is sampled, so the overload bit can be read one half-cycle after the last tick. The pad outputs follow the mode and strobe inputs with no clock in between, and the bench samples them a quarter period after driving. The interrupt carries one register stage after the overload bits and enables, so every interrupt check lands on the falling edge that follows the next rising edge. Thermal alarm and power-up changes are given three clocks to pass through their synchronisers.

// File: rtl/qlm_pkg.sv
// Shared types for the quad line monitor.
// Assumes: a single clock domain; callers synchronise asynchronous inputs.
package qlm_pkg;

    // Function of the shared pad group.
    typedef enum logic {
        PADS_STATUS = 1'b0,
        PADS_BUS    = 1'b1
    } pad_mode_e;

    // Width needed to hold a count from 0 to limit.
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/qlm_sync.sv
// Two-flop synchroniser for a vector of asynchronous levels.
// Assumes: each bit is an independent quasi-static level; no bus coherency.
module qlm_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;

endmodule

// File: rtl/qlm_persist.sv
// Persistence filter for one channel. It counts time-base ticks while the
// synchronised fault flag stays high and declares an overload once
// PERSIST_TICKS ticks have been seen. The count clears as soon as the flag
// drops.
// Assumes: flag_i is already synchronised; tick_i is one cycle wide.
module qlm_persist #(
    parameter int PERSIST_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic flag_i,
    output logic ovl_o
);
    import qlm_pkg::*;

    localparam int CW = cnt_width(PERSIST_TICKS);
    localparam logic [CW-1:0] LIMIT = CW'(PERSIST_TICKS);

    logic [CW-1:0] cnt;

    // Saturating tick counter, cleared while the flag is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!flag_i) begin
            cnt <= '0;
        end else if (tick_i && (cnt != LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ovl_o = (cnt == LIMIT);

    // R1: the count never passes the window length.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    // R1: the overload bit rises only on a tick taken while the flag was high.
    p_rise_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovl_o) |-> $past(tick_i && flag_i));

    // R2: a low flag clears the overload bit at the next edge.
    p_drop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_i |=> !ovl_o);

endmodule

// File: rtl/qlm_irq.sv
// Interrupt qualification and output register. A channel requests an
// interrupt while its overload bit is set, its line is enabled and it is
// not thermally shut down. The output is active low and forced high by
// reset or a cleared enable.
// Assumes: all inputs are synchronous to clk.
module qlm_irq #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] ovl_i,
    input  logic [N_CH-1:0] line_en_i,
    input  logic [N_CH-1:0] therm_shut_i,
    input  logic            irq_en_i,
    output logic            irq_n_o
);

    logic [N_CH-1:0] cause;

    // Per-channel request after line and thermal qualification.
    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            cause[i] = ovl_i[i] && line_en_i[i] && !therm_shut_i[i];
        end
    end

    // Registered active-low interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n_o <= 1'b1;
        end else begin
            irq_n_o <= !(irq_en_i && (|cause));
        end
    end

    // R5: disabled interrupts keep the output high.
    p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> irq_n_o);

    // R4: a thermally shut or disabled line never holds the interrupt alone.
    p_irq_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovl_i & line_en_i & ~therm_shut_i) == '0) |=> irq_n_o);

    // R3: an enabled, qualified overload asserts the interrupt.
    p_irq_assert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && ((ovl_i & line_en_i & ~therm_shut_i) != '0)) |=> !irq_n_o);

endmodule

// File: rtl/qlm_pads.sv
// Pad control for the shared status/data pins. In status mode each pad is
// open drain: it drives 0 or is released. In bus mode the pads carry the
// overload bits on a read and float otherwise.
// Assumes: pad cells drive pad_do_o when pad_oe_o is 1 and are high
// impedance otherwise.
module qlm_pads #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  qlm_pkg::pad_mode_e mode_i,
    input  logic [N_CH-1:0] ovl_i,
    input  logic            therm_alarm_i,
    input  logic [N_CH-1:0] pwr_up_i,
    input  logic [N_CH-1:0] ch_en_i,
    input  logic            cs_n_i,
    input  logic            rd_n_i,
    input  logic            wr_n_i,
    output logic [N_CH-1:0] pad_do_o,
    output logic [N_CH-1:0] pad_oe_o
);
    import qlm_pkg::*;

    logic            bus_read;
    logic [N_CH-1:0] release_vec;

    // Read cycle: selected, read strobe low, no write in progress.
    assign bus_read = !cs_n_i && !rd_n_i && wr_n_i;

    // Per-channel release request for status mode.
    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            release_vec[i] = ovl_i[i] || therm_alarm_i || pwr_up_i[i];
        end
    end

    // Pad data and enable selection by mode.
    always_comb begin
        if (mode_i == PADS_BUS) begin
            pad_do_o = ovl_i;
            pad_oe_o = bus_read ? '1 : '0;
        end else begin
            pad_do_o = '0;
            pad_oe_o = ~ch_en_i | ~release_vec;
        end
    end

    // R8: an unselected bus never drives the pads.
    p_bus_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PADS_BUS && cs_n_i) |-> (pad_oe_o == '0));

    // R7: status mode only ever drives a low level.
    p_status_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PADS_STATUS) |-> (pad_do_o == '0));

    // R9: whenever all pads drive in bus mode, they carry the overload bits.
    p_read_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PADS_BUS && pad_oe_o == '1) |-> (pad_do_o == ovl_i));

endmodule

// File: rtl/quad_line_monitor.sv
// Four-channel line fault status and interrupt unit. It synchronises the
// raw fault levels, filters each over-current flag over a tick-counted
// window, and drives the shared pads and the active-low interrupt.
// Assumes: tick_i is synchronous and one cycle wide; enables and bus
// strobes are synchronous to clk.
module quad_line_monitor #(
    parameter int N_CH          = 4,
    parameter int PERSIST_TICKS = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [N_CH-1:0] ovc_raw_i,
    input  logic            therm_alarm_i,
    input  logic [N_CH-1:0] pwr_up_i,
    input  logic [N_CH-1:0] ch_en_i,
    input  logic [N_CH-1:0] line_en_i,
    input  logic [N_CH-1:0] therm_shut_i,
    input  logic            irq_en_i,
    input  logic            bus_mode_i,
    input  logic            cs_n_i,
    input  logic            rd_n_i,
    input  logic            wr_n_i,
    output logic [N_CH-1:0] pad_do_o,
    output logic [N_CH-1:0] pad_oe_o,
    output logic            irq_n_o
);
    import qlm_pkg::*;

    localparam int SYNC_W = 2 * N_CH + 1;

    logic [SYNC_W-1:0] raw_bundle;
    logic [SYNC_W-1:0] sync_bundle;
    logic [N_CH-1:0]   ovc_s;
    logic [N_CH-1:0]   pwr_up_s;
    logic              therm_s;
    logic [N_CH-1:0]   ovl;
    pad_mode_e         mode;

    // Pack the asynchronous fault levels for one synchroniser.
    assign raw_bundle = {therm_alarm_i, pwr_up_i, ovc_raw_i};

    qlm_sync #(
        .W       (SYNC_W),
        .RST_VAL ('0)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_bundle),
        .q_o   (sync_bundle)
    );

    // Unpack the synchronised levels.
    assign ovc_s    = sync_bundle[N_CH-1:0];
    assign pwr_up_s = sync_bundle[2*N_CH-1:N_CH];
    assign therm_s  = sync_bundle[2*N_CH];

    // One persistence filter per channel.
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        qlm_persist #(
            .PERSIST_TICKS (PERSIST_TICKS)
        ) persist_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .flag_i (ovc_s[g]),
            .ovl_o  (ovl[g])
        );
    end

    assign mode = bus_mode_i ? PADS_BUS : PADS_STATUS;

    qlm_pads #(
        .N_CH (N_CH)
    ) pads_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .ovl_i         (ovl),
        .therm_alarm_i (therm_s),
        .pwr_up_i      (pwr_up_s),
        .ch_en_i       (ch_en_i),
        .cs_n_i        (cs_n_i),
        .rd_n_i        (rd_n_i),
        .wr_n_i        (wr_n_i),
        .pad_do_o      (pad_do_o),
        .pad_oe_o      (pad_oe_o)
    );

    qlm_irq #(
        .N_CH (N_CH)
    ) irq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ovl_i        (ovl),
        .line_en_i    (line_en_i),
        .therm_shut_i (therm_shut_i),
        .irq_en_i     (irq_en_i),
        .irq_n_o      (irq_n_o)
    );

endmodule

// File: tb/quad_line_monitor_tb_top.sv
// Directed bench for quad_line_monitor: one task per scenario.
module quad_line_monitor_tb_top;

    localparam int N  = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [3:0] ovc;
    logic       therm;
    logic [3:0] pwr;
    logic [3:0] chen;
    logic [3:0] lnen;
    logic [3:0] tshut;
    logic       irqen;
    logic       bmode;
    logic       cs_n;
    logic       rd_n;
    logic       wr_n;
    logic [3:0] pdo;
    logic [3:0] poe;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    quad_line_monitor dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .ovc_raw_i     (ovc),
        .therm_alarm_i (therm),
        .pwr_up_i      (pwr),
        .ch_en_i       (chen),
        .line_en_i     (lnen),
        .therm_shut_i  (tshut),
        .irq_en_i      (irqen),
        .bus_mode_i    (bmode),
        .cs_n_i        (cs_n),
        .rd_n_i        (rd_n),
        .wr_n_i        (wr_n),
        .pad_do_o      (pdo),
        .pad_oe_o      (poe),
        .irq_n_o       (irq_n)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    // Bus read of the overload bits, then back to status mode.
    task automatic bus_read(output logic [3:0] d, output logic [3:0] oe);
        @(negedge clk);
        bmode = 1'b1; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
        #5;
        d = pdo; oe = poe;
        @(negedge clk);
        bmode = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick = 0; ovc = 0; therm = 0; pwr = 0; chen = 4'hF;
        lnen = 4'hF; tshut = 0; irqen = 1'b1; bmode = 0; cs_n = 1; rd_n = 1; wr_n = 1;
        cycles(4);
        #5;
        check("R5 reset irq", {3'b0, irq_n}, 4'b0001);
        check("R6 reset pads driving", poe, 4'hF);
        @(negedge clk) rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic t_short_burst();
        logic [3:0] d, oe;
        @(negedge clk) ovc[2] = 1'b1;
        cycles(3);
        pulse_ticks(N - 1);
        @(negedge clk) ovc[2] = 1'b0;
        cycles(4);
        @(negedge clk) ovc[2] = 1'b1;
        cycles(3);
        pulse_ticks(N - 1);
        bus_read(d, oe);
        check("R2 two short bursts do not set", d, 4'b0000);
        @(negedge clk) ovc[2] = 1'b0;
        cycles(4);
    endtask

    task automatic t_window();
        logic [3:0] d, oe;
        @(negedge clk) ovc[1] = 1'b1;
        cycles(3);
        pulse_ticks(N - 1);
        bus_read(d, oe);
        check("R1 one tick short", d, 4'b0000);
        pulse_ticks(1);
        bus_read(d, oe);
        check("R1 window reached", d, 4'b0010);
        check("R9 read enables pads", oe, 4'hF);
    endtask

    task automatic t_irq();
        cycles(1);
        #5 check("R3 irq asserted", {3'b0, irq_n}, 4'b0000);
        @(negedge clk) tshut[1] = 1'b1;
        @(negedge clk);
        #5 check("R4 thermal shutdown releases", {3'b0, irq_n}, 4'b0001);
        @(negedge clk) tshut[1] = 1'b0;
        @(negedge clk) lnen[1] = 1'b0;
        @(negedge clk);
        #5 check("R4 line disable releases", {3'b0, irq_n}, 4'b0001);
        @(negedge clk) lnen[1] = 1'b1;
        @(negedge clk) irqen = 1'b0;
        @(negedge clk);
        #5 check("R5 irq disabled", {3'b0, irq_n}, 4'b0001);
        @(negedge clk) irqen = 1'b1;
        @(negedge clk);
        #5 check("R3 irq back", {3'b0, irq_n}, 4'b0000);
    endtask

    task automatic t_status();
        logic [3:0] d, oe;
        @(negedge clk);
        #5 check("R6 overload releases pad", poe, 4'b1101);
        @(negedge clk) ovc[1] = 1'b0;
        cycles(4);
        #5 check("R6 pad driven after clear", poe, 4'hF);
        check("R3 irq released", {3'b0, irq_n}, 4'b0001);
        bus_read(d, oe);
        check("R2 drop clears bit", d, 4'b0000);
        @(negedge clk) pwr[2] = 1'b1;
        cycles(3);
        #5 check("R6 power-up releases pad", poe, 4'b1011);
        @(negedge clk) chen[2] = 1'b0;
        #5 check("R7 disabled channel drives", poe, 4'hF);
        check("R7 drive level", pdo, 4'h0);
        @(negedge clk) begin chen[2] = 1'b1; pwr[2] = 1'b0; therm = 1'b1; end
        cycles(3);
        #5 check("R6 thermal alarm releases all", poe, 4'h0);
        @(negedge clk) chen = 4'b0101;
        #5 check("R7 enables override alarm", poe, 4'b1010);
        @(negedge clk) begin chen = 4'hF; therm = 1'b0; end
        cycles(3);
    endtask

    task automatic t_bus();
        logic [3:0] d, oe;
        @(negedge clk) begin ovc[0] = 1'b1; ovc[3] = 1'b1; end
        cycles(3);
        pulse_ticks(N);
        bus_read(d, oe);
        check("R9 bit order ch0 on bit0", d, 4'b1001);
        @(negedge clk) begin bmode = 1'b1; cs_n = 1'b1; rd_n = 1'b0; end
        #5 check("R8 deselected floats", poe, 4'h0);
        @(negedge clk) begin cs_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0; end
        #5 check("R8 write floats", poe, 4'h0);
        @(negedge clk) rd_n = 1'b0;
        #5 check("R8 write beats read", poe, 4'h0);
        @(negedge clk) begin bmode = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; end
    endtask

    task automatic t_reset_clears();
        logic [3:0] d, oe;
        @(negedge clk) rst_n = 1'b0;
        cycles(2);
        @(negedge clk) rst_n = 1'b1;
        bus_read(d, oe);
        check("R10 reset clears overload bits", d, 4'b0000);
        pulse_ticks(N - 1);
        bus_read(d, oe);
        check("R10 count restarted from zero", d, 4'b0000);
    endtask

    initial begin
        t_reset();
        t_short_burst();
        t_window();
        t_irq();
        t_status();
        t_bus();
        t_reset_clears();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule